// File: doc/BRIEF.md
# Character LCD Host Command Controller

This block is the host-facing control core of a character-matrix LCD controller. A microcontroller talks to it over a parallel bus with a register select line, a read/write line, an enable strobe and an 8-bit data bus. Each byte on that bus is an instruction, a status read, or a data transfer to or from one of two RAM spaces. The bus can move each byte in a single strobe or in two 4-bit halves. The block decodes instructions and holds the mode state: the entry direction, the auto-shift setting, the display, cursor and blink enables, the line count, the font height and the bus width. It also keeps a 7-bit address counter, a display shift offset and a busy flag.

The character memories sit outside the block and are reached through a simple synchronous port. A request carries the address, the space select, a write enable and the write data. Read data comes back on `mem_rdata` one cycle after the request cycle. Each instruction or data access starts a busy timer that counts cycles of `clk`. Clear and home take the long duration. All other instructions and data accesses take the short one. The host polls the busy flag through the status read.

Top module: `lcd_host_ctrl`

## Requirements
- R1: After reset the busy flag stays high for exactly INIT_CYC clock cycles. The bus is 8-bit, the address counter is 00h, the entry direction is increment and `disp_on` is 0.
- R2: A read with select 0 drives {busy, address counter[6:0]} on `bus_dout`. `bus_doe` is high only while the synchronized enable is high and the read/write line is 1.
- R3: An instruction is decoded by its highest set bit. A byte 0000_1DCB loads `disp_on`=D, `cur_on`=C and `blink_on`=B.
- R4: A data write (select 1, read/write 0) issues exactly one memory write request. The request carries the current address and space. The counter then steps by +1 when the entry direction bit is 1 and by -1 when it is 0.
- R5: A data read (select 1, read/write 1) returns the memory byte at the current address. The counter steps afterwards by the same rule as R4.
- R6: Address steps wrap by space. Character space wraps modulo 64. One-line display space runs 00h..4Fh. Two-line display space runs 00h..27h and 40h..67h: 27h steps up to 40h, 67h to 00h, 40h down to 27h, and 00h down to 67h.
- R7: Byte 01aaaaaa loads aaaaaa and selects character space (`mem_cg`=1, `mem_addr`[6]=0). Byte 1aaaaaaa loads aaaaaaa and selects display space.
- R8: Byte 0001 S R xx with S=1 moves `shift_ofs` modulo 40, +1 when R=1 and -1 when R=0, and leaves the address counter unchanged. With S=0 it steps the address counter in direction R.
- R9: When entry mode 0000_01 I S has S=1, each data access also moves `shift_ofs`. It moves by -1 when I=1 and by +1 when I=0.
- R10: Clear (0000_0001) and home (0000_001x) set the address counter and `shift_ofs` to 0 and select display space. Each keeps busy high for LONG_CYC cycles.
- R11: All other instructions and all data accesses keep busy high for SHORT_CYC cycles. A status read does not start the busy timer.
- R12: Byte 001 L N F xx loads the bus width (L=1 means 8-bit, reported on `wide_bus`), `two_line`=N and `font_tall`=F.
- R13: In 4-bit mode each byte takes two enable cycles on `bus_din`[7:4], high nibble first. Reads return the high nibble and then the low nibble on `bus_dout`[7:4].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_en | input | 1 | Asynchronous enable strobe; writes complete on its falling edge |
| bus_din | input | 8 | Host data in |
| bus_dout | output | 8 | Read data to host |
| bus_doe | output | 1 | Output enable for the data bus |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_cg | output | 1 | 1 character space, 0 display space |
| mem_addr | output | 7 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the request cycle |
| disp_on | output | 1 | Display enable |
| cur_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| two_line | output | 1 | Two-line layout selected |
| font_tall | output | 1 | Tall font selected |
| wide_bus | output | 1 | 1 for the 8-bit bus, 0 for the 4-bit bus |
| shift_ofs | output | 6 | Display shift offset, 0..39 |
| busy | output | 1 | Busy flag |

## Verification
The hardest state to reach from the ports is a 4-bit data read. It mixes nibble pairing with the memory fetch. The fetch has to start on the rising strobe of the first half, and the counter may step only after the second half completes. The bench reaches this state by switching to the 4-bit bus with a single 8-bit function set. It then writes a display address and a data byte as nibble pairs, and reads the byte back as two strobes. Line-boundary wraps are reached by loading the last address of a line directly and then making one access in each direction and each line mode.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;
  localparam int ADDR_W   = 7;
  localparam int OFS_W    = 6;
  localparam int LINE_LEN = 40;

  typedef enum logic [3:0] {
    OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP,
    OP_SHIFT, OP_FUNC, OP_CGADR, OP_DDADR
  } op_e;

  // Next address after one step in the given space and layout.
  function automatic logic [ADDR_W-1:0] ac_next(input logic [ADDR_W-1:0] ac,
                                                input logic up, input logic cg,
                                                input logic two);
    logic [ADDR_W-1:0] r;
    if (cg) begin
      r = {1'b0, up ? ac[5:0] + 6'd1 : ac[5:0] - 6'd1};
    end else if (two) begin
      if (up) r = (ac == 7'h27) ? 7'h40 : (ac == 7'h67) ? 7'h00 : ac + 7'd1;
      else    r = (ac == 7'h40) ? 7'h27 : (ac == 7'h00) ? 7'h67 : ac - 7'd1;
    end else begin
      if (up) r = (ac == 7'h4F) ? 7'h00 : ac + 7'd1;
      else    r = (ac == 7'h00) ? 7'h4F : ac - 7'd1;
    end
    return r;
  endfunction

  // Shift offset step modulo LINE_LEN.
  function automatic logic [OFS_W-1:0] ofs_next(input logic [OFS_W-1:0] ofs,
                                                input logic right);
    logic [OFS_W-1:0] r;
    if (right) r = (ofs == OFS_W'(LINE_LEN - 1)) ? '0 : ofs + 1'b1;
    else       r = (ofs == '0) ? OFS_W'(LINE_LEN - 1) : ofs - 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/lcd_bus_port.sv
module lcd_bus_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic [7:0] bus_din,
  input  logic       four_bit,
  output logic       e_high,
  output logic       evt_rise,
  output logic       evt_fall,
  output logic       nib_low,
  output logic       byte_done,
  output logic [7:0] byte_val
);
  logic [2:0] e_sh;
  logic [3:0] hi_nib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_sh <= '0;
    else        e_sh <= {e_sh[1:0], bus_en};
  end

  assign e_high   = e_sh[1];
  assign evt_rise = e_sh[1] & ~e_sh[2];
  assign evt_fall = ~e_sh[1] & e_sh[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_low <= 1'b0;
      hi_nib  <= '0;
    end else if (!four_bit) begin
      nib_low <= 1'b0;
    end else if (evt_fall) begin
      if (!nib_low) hi_nib <= bus_din[7:4];
      nib_low <= ~nib_low;
    end
  end

  assign byte_done = evt_fall & (~four_bit | nib_low);
  assign byte_val  = four_bit ? {hi_nib, bus_din[7:4]} : bus_din;
endmodule

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
  import lcd_host_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op
);
  always_comb begin
    casez (code)
      8'b1???_????: op = OP_DDADR;
      8'b01??_????: op = OP_CGADR;
      8'b001?_????: op = OP_FUNC;
      8'b0001_????: op = OP_SHIFT;
      8'b0000_1???: op = OP_DISP;
      8'b0000_01??: op = OP_ENTRY;
      8'b0000_001?: op = OP_HOME;
      8'b0000_0001: op = OP_CLEAR;
      default:      op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
  parameter int CW       = 9,
  parameter int INIT_CYC = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= CW'(INIT_CYC);
    else if (start)      cnt <= load;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/lcd_host_ctrl.sv
module lcd_host_ctrl
  import lcd_host_pkg::*;
#(
  parameter int LONG_CYC  = 410,
  parameter int SHORT_CYC = 10,
  parameter int INIT_CYC  = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rs,
  input  logic        bus_rw,
  input  logic        bus_en,
  input  logic [7:0]  bus_din,
  output logic [7:0]  bus_dout,
  output logic        bus_doe,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_cg,
  output logic [6:0]  mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        disp_on,
  output logic        cur_on,
  output logic        blink_on,
  output logic        two_line,
  output logic        font_tall,
  output logic        wide_bus,
  output logic [5:0]  shift_ofs,
  output logic        busy
);
  localparam int MAX_A = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int MAX_C = (MAX_A > INIT_CYC) ? MAX_A : INIT_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  // Internal events, named for the checker.
  logic e_high, evt_rise, evt_fall, nib_low, byte_done;
  logic [7:0] byte_val;
  op_e  op;
  logic instr_exec, data_wr, data_rd, rd_fetch, exec_clear, busy_start;
  logic [CW-1:0] busy_load;

  logic [ADDR_W-1:0] ac_q;
  logic cg_sel_q, inc_q, shen_q;
  logic [7:0] rd_buf;
  logic rd_p1, rd_p2;

  lcd_bus_port u_bus (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_din(bus_din),
    .four_bit(~wide_bus), .e_high(e_high), .evt_rise(evt_rise),
    .evt_fall(evt_fall), .nib_low(nib_low), .byte_done(byte_done),
    .byte_val(byte_val)
  );

  lcd_cmd_decode u_dec (.code(byte_val), .op(op));

  assign instr_exec = byte_done & ~bus_rs & ~bus_rw;
  assign data_wr    = byte_done &  bus_rs & ~bus_rw;
  assign data_rd    = byte_done &  bus_rs &  bus_rw;
  assign rd_fetch   = evt_rise  &  bus_rs &  bus_rw & ~nib_low;
  assign exec_clear = instr_exec & (op == OP_CLEAR);
  assign busy_start = instr_exec | data_wr | data_rd;
  assign busy_load  = (instr_exec && (op == OP_CLEAR || op == OP_HOME))
                      ? CW'(LONG_CYC) : CW'(SHORT_CYC);

  lcd_busy_timer #(.CW(CW), .INIT_CYC(INIT_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(busy_start), .load(busy_load), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q <= '0; cg_sel_q <= 1'b0; inc_q <= 1'b1; shen_q <= 1'b0;
      disp_on <= 1'b0; cur_on <= 1'b0; blink_on <= 1'b0;
      two_line <= 1'b0; font_tall <= 1'b0; wide_bus <= 1'b1;
      shift_ofs <= '0; rd_buf <= '0; rd_p1 <= 1'b0; rd_p2 <= 1'b0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_cg <= 1'b0;
      mem_addr <= '0; mem_wdata <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      rd_p1   <= rd_fetch;
      rd_p2   <= rd_p1;
      if (rd_p2) rd_buf <= mem_rdata;
      if (rd_fetch || data_wr) begin
        mem_req  <= 1'b1;
        mem_we   <= data_wr;
        mem_cg   <= cg_sel_q;
        mem_addr <= cg_sel_q ? {1'b0, ac_q[5:0]} : ac_q;
      end
      if (data_wr) mem_wdata <= byte_val;
      if (data_wr || data_rd) begin
        ac_q <= ac_next(ac_q, inc_q, cg_sel_q, two_line);
        if (shen_q) shift_ofs <= ofs_next(shift_ofs, ~inc_q);
      end
      if (instr_exec) begin
        case (op)
          OP_CLEAR, OP_HOME: begin
            ac_q <= '0; cg_sel_q <= 1'b0; shift_ofs <= '0;
          end
          OP_ENTRY: begin inc_q <= byte_val[1]; shen_q <= byte_val[0]; end
          OP_DISP: begin
            disp_on <= byte_val[2]; cur_on <= byte_val[1]; blink_on <= byte_val[0];
          end
          OP_SHIFT: begin
            if (byte_val[3]) shift_ofs <= ofs_next(shift_ofs, byte_val[2]);
            else             ac_q <= ac_next(ac_q, byte_val[2], cg_sel_q, two_line);
          end
          OP_FUNC: begin
            wide_bus <= byte_val[4]; two_line <= byte_val[3]; font_tall <= byte_val[2];
          end
          OP_CGADR: begin ac_q <= {1'b0, byte_val[5:0]}; cg_sel_q <= 1'b1; end
          OP_DDADR: begin ac_q <= byte_val[6:0]; cg_sel_q <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  // Read path: status or buffered data, split into nibbles on the narrow bus.
  logic [7:0] rd_val;
  assign rd_val   = bus_rs ? rd_buf : {busy, ac_q};
  assign bus_doe  = e_high & bus_rw;
  assign bus_dout = wide_bus ? rd_val
                  : (nib_low ? {rd_val[3:0], 4'h0} : {rd_val[7:4], 4'h0});
endmodule

// File: rtl/lcd_host_chk.sv
module lcd_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rw,
  input logic       bus_doe,
  input logic       mem_req,
  input logic       mem_we,
  input logic       mem_cg,
  input logic [6:0] mem_addr,
  input logic       busy,
  input logic [5:0] shift_ofs,
  input logic       exec_clear,
  input logic [6:0] ac
);
  AST_DOE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> bus_rw); // R2
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> !(mem_req && mem_we)); // R4
  AST_CG_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_cg) |-> !mem_addr[6]); // R7
  AST_OFS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ofs < 6'd40); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    exec_clear |=> (ac == 7'd0 && shift_ofs == 6'd0)); // R10
  AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> busy); // R11
endmodule

bind lcd_host_ctrl lcd_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rw(bus_rw), .bus_doe(bus_doe),
  .mem_req(mem_req), .mem_we(mem_we), .mem_cg(mem_cg), .mem_addr(mem_addr),
  .busy(busy), .shift_ofs(shift_ofs), .exec_clear(exec_clear), .ac(ac_q)
);

// File: tb/sim_lcd_host_ctrl.sv
module sim_lcd_host_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LONG_N  = 410;
  localparam int SHORT_N = 10;
  localparam int INIT_N  = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_rs = 1'b0, bus_rw = 1'b0, bus_en = 1'b0;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout, mem_wdata, mem_rdata;
  logic bus_doe, mem_req, mem_we, mem_cg, busy;
  logic [6:0] mem_addr;
  logic disp_on, cur_on, blink_on, two_line, font_tall, wide_bus;
  logic [5:0] shift_ofs;

  int n_tests = 0, n_fail = 0;
  bit tb_four = 1'b0;
  logic [7:0] dd_mem [128];
  logic [7:0] cg_mem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_host_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_en(bus_en),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .mem_req(mem_req), .mem_we(mem_we), .mem_cg(mem_cg), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .disp_on(disp_on),
    .cur_on(cur_on), .blink_on(blink_on), .two_line(two_line),
    .font_tall(font_tall), .wide_bus(wide_bus), .shift_ofs(shift_ofs), .busy(busy)
  );

  // Synchronous memory model for both spaces.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) dd_mem[i] <= 8'h00;
      for (int i = 0; i < 64; i++)  cg_mem[i] <= 8'h00;
      mem_rdata <= 8'h00;
    end else if (mem_req) begin
      if (mem_we) begin
        if (mem_cg) cg_mem[mem_addr[5:0]] <= mem_wdata;
        else        dd_mem[mem_addr]      <= mem_wdata;
      end else begin
        mem_rdata <= mem_cg ? cg_mem[mem_addr[5:0]] : dd_mem[mem_addr];
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic rs, input logic rw, input logic [7:0] d,
                           output logic [7:0] q, output logic oe);
    @(negedge clk); bus_rs = rs; bus_rw = rw; bus_din = d;
    repeat (2) @(negedge clk); bus_en = 1'b1;
    repeat (9) @(negedge clk); q = bus_dout; oe = bus_doe;
    bus_en = 1'b0;
    repeat (5) @(negedge clk);
    bus_rw = 1'b0;
  endtask

  task automatic write_byte(input logic rs, input logic [7:0] b);
    logic [7:0] q; logic oe;
    if (tb_four) begin
      bus_cycle(rs, 1'b0, {b[7:4], 4'h0}, q, oe);
      bus_cycle(rs, 1'b0, {b[3:0], 4'h0}, q, oe);
    end else bus_cycle(rs, 1'b0, b, q, oe);
  endtask

  task automatic read_byte(input logic rs, output logic [7:0] v);
    logic [7:0] q1, q2; logic oe;
    bus_cycle(rs, 1'b1, 8'h00, q1, oe);
    if (tb_four) begin
      bus_cycle(rs, 1'b1, 8'h00, q2, oe);
      v = {q1[7:4], q2[7:4]};
    end else v = q1;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
  endtask

  task automatic status_is(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    wait_idle();
    read_byte(1'b0, v);
    chk(tag, v, exp);
  endtask

  // Single 8-bit strobe, then counts the cycles that busy stays high.
  task automatic measure_busy(input logic rs, input logic [7:0] d, output int n);
    wait_idle();
    @(negedge clk); bus_rs = rs; bus_rw = 1'b0; bus_din = d;
    repeat (2) @(negedge clk); bus_en = 1'b1;
    repeat (9) @(negedge clk); bus_en = 1'b0;
    for (int k = 0; k < 6 && !busy; k++) @(negedge clk);
    n = 0;
    while (busy && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    int n = 0;
    while (busy && n < 2000) begin n++; @(negedge clk); end
    chk("R1 init busy cycles", n, INIT_N);
    chk("R1 disp_on after reset", disp_on, 0);
    chk("R1 wide_bus after reset", wide_bus, 1);
    chk("R1 shift_ofs after reset", shift_ofs, 0);
    status_is("R1 address after reset", 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] q; logic oe;
    write_byte(1'b0, 8'h02);
    bus_cycle(1'b0, 1'b1, 8'h00, q, oe);
    chk("R2 status shows busy", q, 8'h80);
    chk("R2 doe during read", oe, 1);
    wait_idle();
    bus_cycle(1'b0, 1'b1, 8'h00, q, oe);
    chk("R2 status idle", q, 8'h00);
    chk("R11 status read starts no busy", busy, 0);
    bus_rw = 1'b1; repeat (3) @(negedge clk);
    chk("R2 doe low with enable low", bus_doe, 0);
    bus_rw = 1'b0;
  endtask

  task automatic t_func_display();
    write_byte(1'b0, 8'h34);
    chk("R12 font_tall set", font_tall, 1);
    chk("R12 two_line clear", two_line, 0);
    write_byte(1'b0, 8'h38);
    chk("R12 two_line set", two_line, 1);
    chk("R12 font_tall clear", font_tall, 0);
    write_byte(1'b0, 8'h0F);
    chk("R3 all enables", {disp_on, cur_on, blink_on}, 3'b111);
    write_byte(1'b0, 8'h08);
    chk("R3 all off", {disp_on, cur_on, blink_on}, 3'b000);
    write_byte(1'b0, 8'h0C);
    chk("R3 display only", {disp_on, cur_on, blink_on}, 3'b100);
  endtask

  task automatic t_write_read();
    logic [7:0] v;
    write_byte(1'b0, 8'h85);
    write_byte(1'b1, 8'h41);
    write_byte(1'b1, 8'h42);
    chk("R4 first byte stored", dd_mem[5], 8'h41);
    chk("R4 second byte stored", dd_mem[6], 8'h42);
    status_is("R4 counter after writes", 8'h07);
    write_byte(1'b0, 8'h85);
    read_byte(1'b1, v); chk("R5 read first", v, 8'h41);
    read_byte(1'b1, v); chk("R5 read second", v, 8'h42);
    status_is("R5 counter after reads", 8'h07);
    write_byte(1'b0, 8'h7F);
    write_byte(1'b1, 8'hAA);
    chk("R7 char space write", cg_mem[63], 8'hAA);
    chk("R7 display space untouched", dd_mem[63], 8'h00);
    status_is("R6 char space wrap", 8'h00);
  endtask

  task automatic t_busy_short();
    int n;
    measure_busy(1'b0, 8'h0C, n);
    chk("R11 instruction busy", n, SHORT_N);
    measure_busy(1'b1, 8'h00, n);
    chk("R11 data write busy", n, SHORT_N);
  endtask

  task automatic t_wrap();
    write_byte(1'b0, 8'h30);
    write_byte(1'b0, 8'h06);
    write_byte(1'b0, 8'hCF); write_byte(1'b1, 8'h01);
    status_is("R6 one-line 4F up", 8'h00);
    write_byte(1'b0, 8'h38);
    write_byte(1'b0, 8'hA7); write_byte(1'b1, 8'h02);
    status_is("R6 two-line 27 up", 8'h40);
    write_byte(1'b0, 8'hE7); write_byte(1'b1, 8'h03);
    status_is("R6 two-line 67 up", 8'h00);
    write_byte(1'b0, 8'h04);
    write_byte(1'b0, 8'hC0); write_byte(1'b1, 8'h04);
    status_is("R6 two-line 40 down", 8'h27);
    write_byte(1'b0, 8'h80); write_byte(1'b1, 8'h05);
    status_is("R6 two-line 00 down", 8'h67);
    chk("R4 decrement write stored", dd_mem[0], 8'h05);
    write_byte(1'b0, 8'h06);
  endtask

  task automatic t_shift();
    write_byte(1'b0, 8'h83);
    write_byte(1'b0, 8'h1C);
    chk("R8 shift right", shift_ofs, 1);
    write_byte(1'b0, 8'h18);
    write_byte(1'b0, 8'h18);
    chk("R8 shift left wraps", shift_ofs, 39);
    status_is("R8 counter unchanged by shift", 8'h03);
    write_byte(1'b0, 8'h14);
    status_is("R8 cursor right", 8'h04);
    write_byte(1'b0, 8'h10);
    status_is("R8 cursor left", 8'h03);
    write_byte(1'b0, 8'h1F);
    chk("R3 priority: shift wraps to 0", shift_ofs, 0);
    chk("R3 priority: display unchanged", {disp_on, cur_on, blink_on}, 3'b100);
  endtask

  task automatic t_entry_home_clear();
    int n;
    write_byte(1'b0, 8'h07);
    write_byte(1'b1, 8'h10);
    chk("R9 increment shifts left", shift_ofs, 39);
    write_byte(1'b0, 8'h05);
    write_byte(1'b1, 8'h11);
    chk("R9 decrement shifts right", shift_ofs, 0);
    write_byte(1'b1, 8'h12);
    chk("R9 second right shift", shift_ofs, 1);
    write_byte(1'b0, 8'h92);
    measure_busy(1'b0, 8'h02, n);
    chk("R10 home busy", n, LONG_N);
    chk("R10 home offset", shift_ofs, 0);
    status_is("R10 home address", 8'h00);
    write_byte(1'b0, 8'h06);
    write_byte(1'b0, 8'h40);
    write_byte(1'b1, 8'h11);
    write_byte(1'b0, 8'h1C);
    measure_busy(1'b0, 8'h01, n);
    chk("R10 clear busy", n, LONG_N);
    chk("R10 clear offset", shift_ofs, 0);
    status_is("R10 clear address", 8'h00);
    write_byte(1'b1, 8'h77);
    chk("R10 clear selects display space", dd_mem[0], 8'h77);
  endtask

  task automatic t_four_bit();
    logic [7:0] v;
    write_byte(1'b0, 8'h28);
    chk("R12 narrow bus selected", wide_bus, 0);
    tb_four = 1'b1;
    write_byte(1'b0, 8'h92);
    write_byte(1'b1, 8'h3C);
    chk("R13 nibble write stored", dd_mem[8'h12], 8'h3C);
    status_is("R13 nibble status", 8'h13);
    write_byte(1'b0, 8'h92);
    read_byte(1'b1, v);
    chk("R13 nibble data read", v, 8'h3C);
    status_is("R13 counter after nibble read", 8'h13);
    write_byte(1'b0, 8'h38);
    chk("R12 wide bus restored", wide_bus, 1);
    tb_four = 1'b0;
    status_is("R13 wide status after switch", 8'h13);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_status();
    t_func_display();
    t_write_read();
    t_busy_short();
    t_wrap();
    t_shift();
    t_entry_home_clear();
    t_four_bit();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule